// File: doc/BRIEF.md
# Chip-Select External Bus Controller

This block is the master side of a synchronous external memory bus. Internal agents hand it single read or write requests over a valid/ready stream. It decodes the top bits of a 27-bit internal byte address into one of six chip-select regions, each 16 MB wide. It then runs a bus cycle on a 22-bit address bus and a 16-bit data bus. No external device can stretch or acknowledge that cycle, so each cycle runs a length fixed by the settings of its region.

Each region has its own enable, its own wait-state count (four bits, so the cycle lasts 1 + N clocks) and its own port width. The port width is either a full 16-bit port or an 8-bit port wired to the upper lane. On an 8-bit port, a request that uses both lanes becomes two back-to-back byte cycles. Read data is captured at the edge that ends the last clock of each bus cycle. One response beat per request reports the result. The response has no back-pressure, and `req_ready` stays low from acceptance until the cycle after that beat. A small write port loads the per-region settings. Any change to those settings applies from the next accepted request.

Top module: `ebc_top`

## Requirements
- R1: `req_ready` is high only while the controller is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low up to and including the response beat, and is high again on the clock after that beat.
- R2: Address bits [26:24] select the region. Regions 0 to 5 drive the matching active-low `bus_cs_n[i]` for the whole bus cycle, and never more than one select is low at a time. Bits [23:22] are not driven onto the bus, and `bus_a` carries bits [21:0].
- R3: A request to region 6 or 7, or to a disabled region, asserts no strobe. Its response beat comes on the clock right after acceptance, with `rsp_hit`=0 and `rsp_rdata`=0.
- R4: With wait field N, each bus cycle keeps its strobes asserted for exactly N+1 clocks. The first of those clocks follows the accepting edge.
- R5: `bus_rw` is 1 in read cycles and 0 in write cycles. `bus_oe_n` is low only in read cycles. `bus_doe` is high only in write cycles. When no cycle is running, `bus_rw`=1 and `bus_oe_n`, `bus_eb0_n`, `bus_eb1_n` and all selects are high.
- R6: On a 16-bit port there is a single cycle. `bus_eb0_n` = NOT `req_be[1]` (upper lane D[15:8]), `bus_eb1_n` = NOT `req_be[0]` (lower lane D[7:0]), `bus_a` = address[21:0], and `bus_dout` = write data.
- R7: On an 8-bit port with `req_be`=11 there are two back-to-back cycles. The upper byte goes first with `bus_a[0]`=0, then the lower byte with `bus_a[0]`=1. Each byte travels on D[15:8], with `bus_eb0_n` low and `bus_eb1_n` high.
- R8: On an 8-bit port with a single lane (or none), there is one cycle. Lane 10 uses the upper byte with `bus_a[0]`=0. Lane 01 uses the lower byte with `bus_a[0]`=1. For `req_be`=00 the cycle is made with both enables high.
- R9: For a read, each byte lane of `rsp_rdata` holds the bus value present in the last clock of the cycle that carried it. A lane that was not enabled reads 0, and writes return 0.
- R10: The wait count and port width are sampled when a request is accepted. A write to the settings of a region while its cycle runs does not change that cycle.
- R11: After reset all regions are disabled, with width 16 and wait 0. The bus is idle and `req_ready` is high.
- R12: `rsp_valid` is a one-clock pulse on the clock after the final bus clock. During that pulse all strobes are inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Settings write strobe |
| cfg_idx | input | 3 | Region to write (6 and 7 ignored) |
| cfg_en | input | 1 | Region enable |
| cfg_narrow | input | 1 | 1 = 8-bit port on D[15:8], 0 = 16-bit port |
| cfg_waits | input | 4 | Wait states N, cycle is N+1 clocks |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready (idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 27 | Byte address, bits [26:24] region |
| req_be | input | 2 | Lane enables, bit1 upper, bit0 lower |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Response beat, one clock |
| rsp_hit | output | 1 | 1 if a bus cycle was made |
| rsp_rdata | output | 16 | Read data |
| bus_a | output | 22 | External address |
| bus_cs_n | output | 6 | Active-low chip selects |
| bus_rw | output | 1 | High read, low write |
| bus_oe_n | output | 1 | Active-low output enable |
| bus_eb0_n | output | 1 | Active-low upper lane enable |
| bus_eb1_n | output | 1 | Active-low lower lane enable |
| bus_dout | output | 16 | Write data to the pads |
| bus_doe | output | 1 | Pad drive enable for bus_dout |
| bus_din | input | 16 | Read data from the pads |

## Verification
The bench sweeps every region, lane pattern and direction over both port widths, and every wait count on both widths. It changes the read data on every clock, so a design that captured too early would return a stale byte. It watches the byte split on an 8-bit port: a swapped order, a wrong `bus_a[0]`, or data left on the lower lane would all show at the pins. Settings are rewritten in the middle of a cycle, and a design that consumed live settings would shorten that cycle. The bench also sends requests to unmapped and disabled regions, where any stray strobe or a late or missing response beat is flagged.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
  localparam int WAIT_W = 4;
  localparam int DATA_W = 16;
  localparam int LANE_W = DATA_W / 2;

  typedef struct packed {
    logic              en;
    logic              narrow;
    logic [WAIT_W-1:0] waits;
  } cs_cfg_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUS  = 2'd1,
    ST_DONE = 2'd2
  } ebc_state_e;
endpackage

// File: rtl/ebc_cfg_regs.sv
module ebc_cfg_regs
  import ebc_pkg::*;
#(
  parameter int NUM_CS = 6,
  parameter int REG_W  = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [REG_W-1:0]       idx,
  input  cs_cfg_t                wr,
  output cs_cfg_t [NUM_CS-1:0]   cfg_q
);
  for (genvar g = 0; g < NUM_CS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[g] <= '0;
      end else if (we && idx == REG_W'(g)) begin
        cfg_q[g] <= wr;
      end
    end
  end
endmodule

// File: rtl/ebc_decode.sv
module ebc_decode
  import ebc_pkg::*;
#(
  parameter int NUM_CS = 6,
  parameter int REG_W  = 3
) (
  input  logic [REG_W-1:0]     region,
  input  cs_cfg_t [NUM_CS-1:0] cfg_q,
  output logic                 hit,
  output cs_cfg_t              sel_cfg
);
  always_comb begin
    hit     = 1'b0;
    sel_cfg = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (region == REG_W'(i)) begin
        hit     = cfg_q[i].en;
        sel_cfg = cfg_q[i];
      end
    end
  end
endmodule

// File: rtl/ebc_cycle.sv
module ebc_cycle
  import ebc_pkg::*;
#(
  parameter int NUM_CS = 6,
  parameter int REG_W  = 3,
  parameter int EXT_AW = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [EXT_AW-1:0] req_a,
  input  logic [1:0]        req_be,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [REG_W-1:0]  region,
  input  logic              hit,
  input  cs_cfg_t           sel_cfg,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [EXT_AW-1:0] bus_a,
  output logic [NUM_CS-1:0] bus_cs_n,
  output logic              bus_rw,
  output logic              bus_oe_n,
  output logic              bus_eb0_n,
  output logic              bus_eb1_n,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_doe,
  input  logic [DATA_W-1:0] bus_din
);
  ebc_state_e        st;
  logic              wr_q, narrow_q, lower_q, last_q, hit_q;
  logic [1:0]        be_q;
  logic [EXT_AW-1:0] a_q;
  logic [DATA_W-1:0] wd_q, rd_q;
  logic [REG_W-1:0]  idx_q;
  logic [WAIT_W-1:0] waits_q, cnt;
  logic              act;
  logic [DATA_W-1:0] lane_mask;

  assign act       = (st == ST_BUS);
  assign lane_mask = {{LANE_W{be_q[1]}}, {LANE_W{be_q[0]}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      wr_q <= 1'b0; narrow_q <= 1'b0; lower_q <= 1'b0; last_q <= 1'b0;
      hit_q <= 1'b0; be_q <= '0; a_q <= '0; wd_q <= '0; rd_q <= '0;
      idx_q <= '0; waits_q <= '0; cnt <= '0;
    end else begin
      case (st)
        ST_IDLE: if (req_valid) begin
          wr_q     <= req_write;
          be_q     <= req_be;
          a_q      <= req_a;
          wd_q     <= req_wdata;
          idx_q    <= region;
          narrow_q <= sel_cfg.narrow;
          waits_q  <= sel_cfg.waits;
          cnt      <= sel_cfg.waits;
          lower_q  <= sel_cfg.narrow & ~req_be[1];
          last_q   <= ~(sel_cfg.narrow & (&req_be));
          rd_q     <= '0;
          hit_q    <= hit;
          st       <= hit ? ST_BUS : ST_DONE;
        end
        ST_BUS: begin
          if (cnt == '0) begin
            if (!wr_q) begin
              if (!narrow_q) rd_q <= bus_din & lane_mask;
              else if (lower_q) rd_q[LANE_W-1:0] <= bus_din[DATA_W-1:LANE_W] & {LANE_W{be_q[0]}};
              else rd_q[DATA_W-1:LANE_W] <= bus_din[DATA_W-1:LANE_W] & {LANE_W{be_q[1]}};
            end
            if (last_q) begin
              st <= ST_DONE;
            end else begin
              lower_q <= 1'b1;
              last_q  <= 1'b1;
              cnt     <= waits_q;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (st == ST_IDLE);
  assign rsp_valid = (st == ST_DONE);
  assign rsp_hit   = hit_q;
  assign rsp_rdata = rd_q;

  always_comb begin
    for (int i = 0; i < NUM_CS; i++) bus_cs_n[i] = ~(act && idx_q == REG_W'(i));
    bus_rw   = ~(act & wr_q);
    bus_oe_n = ~(act & ~wr_q);
    bus_doe  = act & wr_q;
    if (narrow_q) begin
      bus_a     = {a_q[EXT_AW-1:1], lower_q};
      bus_eb0_n = ~(act & (lower_q ? be_q[0] : be_q[1]));
      bus_eb1_n = 1'b1;
      bus_dout  = {(lower_q ? wd_q[LANE_W-1:0] : wd_q[DATA_W-1:LANE_W]), {LANE_W{1'b0}}};
    end else begin
      bus_a     = a_q;
      bus_eb0_n = ~(act & be_q[1]);
      bus_eb1_n = ~(act & be_q[0]);
      bus_dout  = wd_q;
    end
  end
endmodule

// File: rtl/ebc_top.sv
module ebc_top
  import ebc_pkg::*;
#(
  parameter int NUM_CS = 6,
  parameter int REG_W  = 3,
  parameter int OFFS_W = 24,
  parameter int EXT_AW = 22,
  localparam int IN_AW = OFFS_W + REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [REG_W-1:0]  cfg_idx,
  input  logic              cfg_en,
  input  logic              cfg_narrow,
  input  logic [WAIT_W-1:0] cfg_waits,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [IN_AW-1:0]  req_addr,
  input  logic [1:0]        req_be,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [EXT_AW-1:0] bus_a,
  output logic [NUM_CS-1:0] bus_cs_n,
  output logic              bus_rw,
  output logic              bus_oe_n,
  output logic              bus_eb0_n,
  output logic              bus_eb1_n,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_doe,
  input  logic [DATA_W-1:0] bus_din
);
  cs_cfg_t [NUM_CS-1:0] cfg_q;
  cs_cfg_t              cfg_wr, sel_cfg;
  logic                 hit;
  logic [REG_W-1:0]     region;

  assign cfg_wr = '{en: cfg_en, narrow: cfg_narrow, waits: cfg_waits};
  assign region = req_addr[OFFS_W +: REG_W];

  ebc_cfg_regs #(.NUM_CS(NUM_CS), .REG_W(REG_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_idx), .wr(cfg_wr), .cfg_q(cfg_q)
  );

  ebc_decode #(.NUM_CS(NUM_CS), .REG_W(REG_W)) u_dec (
    .region(region), .cfg_q(cfg_q), .hit(hit), .sel_cfg(sel_cfg)
  );

  ebc_cycle #(.NUM_CS(NUM_CS), .REG_W(REG_W), .EXT_AW(EXT_AW)) u_cyc (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_a(req_addr[EXT_AW-1:0]), .req_be(req_be),
    .req_wdata(req_wdata), .region(region), .hit(hit), .sel_cfg(sel_cfg),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata),
    .bus_a(bus_a), .bus_cs_n(bus_cs_n), .bus_rw(bus_rw), .bus_oe_n(bus_oe_n),
    .bus_eb0_n(bus_eb0_n), .bus_eb1_n(bus_eb1_n), .bus_dout(bus_dout),
    .bus_doe(bus_doe), .bus_din(bus_din)
  );
endmodule

// File: rtl/ebc_chk.sv
module ebc_chk
  import ebc_pkg::*;
#(
  parameter int NUM_CS = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic [NUM_CS-1:0] bus_cs_n,
  input logic              bus_rw,
  input logic              bus_oe_n,
  input logic              bus_doe
);
  localparam int RUN_MAX = 2 << WAIT_W;
  logic [WAIT_W+2:0] run;
  logic              busy;

  assign busy = ~(&bus_cs_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= '0;
    else if (busy) run <= run + 1'b1;
    else run <= '0;
  end

  p_single_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~bus_cs_n));
  p_oe_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe_n |-> (bus_rw && busy));
  p_doe_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_doe |-> (!bus_rw && busy));
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!busy && !rsp_valid));
  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  p_rsp_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));
  p_rsp_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !busy);
  p_miss_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> ($past(req_ready) && !$past(busy)));
  p_cycle_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run <= RUN_MAX[WAIT_W+2:0]);
endmodule

bind ebc_top ebc_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .bus_cs_n(bus_cs_n),
  .bus_rw(bus_rw), .bus_oe_n(bus_oe_n), .bus_doe(bus_doe)
);

// File: tb/tb_ebc_top.sv
module tb_ebc_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_en = 0, cfg_narrow = 0;
  logic [2:0] cfg_idx = '0;
  logic [3:0] cfg_waits = '0;
  logic req_valid = 0, req_ready, req_write = 0;
  logic [26:0] req_addr = '0;
  logic [1:0] req_be = '0;
  logic [15:0] req_wdata = '0;
  logic rsp_valid, rsp_hit;
  logic [15:0] rsp_rdata;
  logic [21:0] bus_a;
  logic [5:0] bus_cs_n;
  logic bus_rw, bus_oe_n, bus_eb0_n, bus_eb1_n, bus_doe;
  logic [15:0] bus_dout;
  logic [15:0] bus_din = '0;

  int n_run = 0, n_fail = 0;
  int en_a [8], nar_a [8], ws_a [8];

  always #10 clk = ~clk;

  ebc_top dut (.*);

  function automatic logic [15:0] pat(input logic [21:0] a, input int t);
    return {a[7:0] ^ 8'(t * 37), a[15:8] + 8'(t)};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(input int idx, input int en, input int nar, input int ws);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 3'(idx); cfg_en = en[0]; cfg_narrow = nar[0]; cfg_waits = 4'(ws);
    @(negedge clk);
    cfg_we = 0;
    if (idx < 6) begin en_a[idx] = en; nar_a[idx] = nar; ws_a[idx] = ws; end
  endtask

  task automatic do_txn(input int r, input bit w, input logic [1:0] be,
                        input logic [21:0] lo, input logic [15:0] wd);
    bit hit, nar, got;
    int n, nph, tend, t;
    logic [21:0] pa [2];
    bit plow [2];
    logic [15:0] exp_rd;
    logic [63:0] ev, av, fa, fe;
    bit bad, rbad;
    string rq;
    hit = (r < 6) && (en_a[r] != 0);
    nar = hit && (nar_a[r] != 0);
    n   = hit ? ws_a[r] : 0;
    if (!nar) begin nph = 1; pa[0] = lo; plow[0] = 0; end
    else if (be == 2'b11) begin
      nph = 2; pa[0] = {lo[21:1], 1'b0}; plow[0] = 0; pa[1] = {lo[21:1], 1'b1}; plow[1] = 1;
    end else if (be == 2'b10) begin nph = 1; pa[0] = {lo[21:1], 1'b0}; plow[0] = 0; end
    else begin nph = 1; pa[0] = {lo[21:1], 1'b1}; plow[0] = 1; end
    tend = hit ? nph * (n + 1) : 0;
    exp_rd = '0;
    if (hit && !w) begin
      if (!nar) exp_rd = pat(pa[0], n) & {{8{be[1]}}, {8{be[0]}}};
      else for (int p = 0; p < nph; p++) begin
        if (plow[p]) exp_rd[7:0] = pat(pa[p], p * (n + 1) + n)[15:8] & {8{be[0]}};
        else exp_rd[15:8] = pat(pa[p], p * (n + 1) + n)[15:8] & {8{be[1]}};
      end
    end
    rq = !hit ? "R3" : (!nar ? "R6" : (be == 2'b11 ? "R7" : "R8"));
    @(negedge clk);
    req_valid = 1; req_write = w; req_be = be; req_wdata = wd;
    req_addr = {3'(r), 2'b10, lo};
    @(negedge clk);
    req_valid = 0;
    t = 0; got = 0; bad = 0; rbad = 0; fa = '0; fe = '0;
    while (t < 80) begin
      if (rsp_valid) begin got = 1; break; end
      if (t < tend) begin
        int p; logic [15:0] ed;
        p = t / (n + 1);
        if (!nar) ed = wd; else ed = {(plow[p] ? wd[7:0] : wd[15:8]), 8'h00};
        ev = {15'd0, ~(6'd1 << r), ~w, w, (nar ? (plow[p] ? ~be[0] : ~be[1]) : ~be[1]),
              (nar ? 1'b1 : ~be[0]), w, pa[p], (w ? ed : 16'h0)};
      end else begin
        ev = {15'd0, 6'h3f, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 22'h0, 16'h0};
      end
      av = {15'd0, bus_cs_n, bus_rw, bus_oe_n, bus_eb0_n, bus_eb1_n, bus_doe,
            (t < tend ? bus_a : 22'h0), ((t < tend && w) ? bus_dout : 16'h0)};
      if (av != ev && !bad) begin bad = 1; fa = av; fe = ev; end
      if (req_ready) rbad = 1;
      bus_din = pat(bus_a, t);
      @(negedge clk);
      t++;
    end
    chk(!bad, rq, "bus pins {cs,rw,oe,eb0,eb1,doe,a,dout}", fa, fe);
    chk(got && t == tend, "R4", "response clock index", 64'(t), 64'(tend));
    chk(!rbad, "R1", "ready low while busy", 64'(rbad), 64'd0);
    chk(got && rsp_hit == hit && rsp_rdata == exp_rd && bus_cs_n == 6'h3f,
        (hit ? "R9" : "R3"), "rsp {hit,rdata}", {47'd0, rsp_hit, rsp_rdata}, {47'd0, hit, exp_rd});
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R12", "pulse ends, ready back", {rsp_valid, req_ready}, 64'b01);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin en_a[i] = 0; nar_a[i] = 0; ws_a[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11: idle bus and ready after reset
    chk(bus_cs_n == 6'h3f && bus_oe_n && bus_rw && bus_eb0_n && bus_eb1_n && !bus_doe,
        "R11", "idle pins", {bus_cs_n, bus_oe_n, bus_rw}, {6'h3f, 2'b11});
    chk(req_ready && !rsp_valid, "R11", "ready after reset", {req_ready, rsp_valid}, 64'b10);
    // R11/R3: regions disabled after reset
    do_txn(0, 0, 2'b11, 22'h012345, 16'h0);

    // R2..R9 sweep over regions, directions and lane patterns
    for (int r = 0; r < 6; r++) set_cfg(r, (r != 4), r % 2, (r * 3) % 16);
    for (int r = 0; r < 8; r++)
      for (int w = 0; w < 2; w++)
        for (int b = 0; b < 4; b++)
          do_txn(r, w[0], 2'(b), 22'h15A3C1 ^ 22'(r << 4) ^ 22'(b << 9), 16'hC35A ^ 16'(r * 257 + b));

    // R4: every wait count on both widths
    for (int ws = 0; ws < 16; ws++) begin
      set_cfg(1, 1, 1, ws);
      set_cfg(2, 1, 0, ws);
      do_txn(1, 0, 2'b11, 22'h2A5B70 + 22'(ws), 16'h0);
      do_txn(2, 1, 2'b11, 22'h0F0F00 + 22'(ws), 16'hBEEF ^ 16'(ws));
    end

    // R10: settings rewritten mid-cycle do not touch the running cycle
    set_cfg(3, 1, 1, 3);
    fork
      do_txn(3, 0, 2'b11, 22'h333332, 16'h0);
      begin
        repeat (3) @(negedge clk);
        cfg_we = 1; cfg_idx = 3'd3; cfg_en = 1; cfg_narrow = 0; cfg_waits = 4'd0;
        @(negedge clk);
        cfg_we = 0;
      end
    join
    en_a[3] = 1; nar_a[3] = 0; ws_a[3] = 0;
    // R10: new settings apply on the next request
    do_txn(3, 0, 2'b11, 22'h333332, 16'h0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule